// File: doc/BRIEF.md
# Multi-Lane Polynomial Parity Coder

This block turns a serial bit stream into a stream of coded bits. It holds four 24-bit feedback shift registers, called lanes A to D. Each lane has two programmable polynomial words. The feedback word decides which state bits are flipped when the feedback bit is 1. The feedforward word chooses which state bits are folded into the lane's output parity. A mode field selects the lane arrangement:

- all four lanes running on their own;
- lane A alone;
- lanes A and B chained into a single 48-bit register.

Each lane has an input enable that lets the data bit into its feedback path. The data bit always reaches the feedforward path, whatever the input enables say. Each lane also has an output enable. The coded bit is the XOR of the lane outputs whose output enable is set.

Configuration is written through a small write-only port with a 4-bit address. Data bits are presented with a valid strobe, and each valid bit produces one coded bit one cycle later. A busy flag rises with the first data bit and stays high until a synchronous clear. While busy is high, writes to the mode field are ignored. The clear zeroes all lane states.

Top module: `multi_lfsr_coder`

## Requirements
- R1: While reset is asserted and after it is released, outValid, outBit and busy are 0 and every lane state is 0. The reset mode is 00, which gives four independent lanes.
- R2: In mode 00 or 01, all four lanes shift on every valid bit. The coded bit is the XOR of the outputs of the lanes whose output enable is set.
- R3: A lane steps as follows. First, fb = state[23] XOR (inBit AND inEn). Then the state shifts left one place with 0 entering bit 0. Finally, if fb is 1, the feedback polynomial word is XORed into the shifted state.
- R4: The output of a lane is the XOR reduction of (state AND feedforward word), XORed with (inBit AND feedforward bit 0). It is taken from the state before the step. The coded bit appears on outBit, with outValid high, in the cycle after inValid was high.
- R5: When a lane's input enable is 0, the data bit stays out of that lane's feedback. It still reaches the lane's feedforward term.
- R6: Mode 10 steps lane A only. Lanes B, C and D hold their state, and their outputs are excluded even when their output enables are set.
- R7: Mode 11 chains the lanes as {B,A}, a 48-bit register, with the feedback word {fbB,fbA} and the feedforward word {ffB,ffA}. The top bit of A shifts into B. The feedback uses input enable bit 0. The chained output is gated by output enable bit 0 alone. Lanes C and D hold and are excluded.
- R8: A lane whose output enable bit is 0 does not contribute to the coded bit.
- R9: busy goes high in the cycle after the first valid bit and stays high until a clear. A write to address 0 (mode, bits 1:0) while busy is high is dropped.
- R10: syncClear zeroes every lane state, busy and outValid in the next cycle. It takes priority over a valid bit in the same cycle.
- R11: In a cycle after one with inValid low, outValid is 0.
- R12: The configuration map is as follows:
  - address 0: mode in bits 1:0;
  - address 1: input enables in bits 3:0 and output enables in bits 23:20, lane A in the lowest bit of each field;
  - addresses 2 to 5: feedback words for lanes A to D;
  - addresses 6 to 9: feedforward words for lanes A to D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration address |
| cfgWdata | input | 24 | Configuration write data |
| inValid | input | 1 | Data bit valid |
| inBit | input | 1 | Serial data bit |
| syncClear | input | 1 | Synchronous clear of lane states and busy |
| outBit | output | 1 | Coded output bit |
| outValid | output | 1 | Coded bit valid |
| busy | output | 1 | Coding in progress |

## Verification
The bench targets the chained mode. A design that did not carry the top bit of A into B, or that took the feedback from A's top bit, would drift from the 48-bit reference within about 24 bits. A design that gated the chained output with B's enable would give wrong bits whenever the two enables differ.

The bench also runs streams with the input enables cleared and the feedforward bit 0 set. A design that also gated the feedforward path would then lose the direct term.

A mode write made while busy must be dropped. If it took effect, the next bits would stop matching the four-lane reference. A clear raised together with a valid bit must leave the lanes at zero rather than one step beyond.

// File: rtl/coder_pkg.sv
package coder_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD     = 2'b00,
    MODE_QUAD_ALT = 2'b01,
    MODE_SOLO     = 2'b10,
    MODE_PAIR     = 2'b11
  } coderMode_t;

  typedef struct packed {
    logic shift;
    logic clear;
  } stepStrobe_t;

endpackage

// File: rtl/coder_ctrl.sv
module coder_ctrl
  import coder_pkg::*;
#(
  parameter int WIDTH     = 24,
  parameter int LANES     = 4,
  parameter int ADDR_W    = 4,
  parameter int OUTEN_LSB = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [ADDR_W-1:0]            cfgAddr,
  input  logic [WIDTH-1:0]             cfgWdata,
  input  logic                         inValid,
  input  logic                         syncClear,
  output stepStrobe_t                  strobe,
  output coderMode_t                   mode,
  output logic [LANES-1:0]             inEn,
  output logic [LANES-1:0]             outEn,
  output logic [LANES-1:0][WIDTH-1:0]  fbPoly,
  output logic [LANES-1:0][WIDTH-1:0]  ffPoly,
  output logic                         busy
);

  localparam int ADDR_MODE = 0;
  localparam int ADDR_EN   = 1;
  localparam int FB_BASE   = 2;
  localparam int FF_BASE   = FB_BASE + LANES;

  logic busyQ;
  coderMode_t modeQ;
  logic [LANES-1:0] inEnQ, outEnQ;

  always_comb begin
    strobe.clear = syncClear;
    strobe.shift = inValid && !syncClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      modeQ  <= MODE_QUAD;
      inEnQ  <= '0;
      outEnQ <= '0;
    end else begin
      if (syncClear)    busyQ <= 1'b0;
      else if (inValid) busyQ <= 1'b1;
      if (cfgWe && cfgAddr == ADDR_W'(ADDR_MODE) && !busyQ)
        modeQ <= coderMode_t'(cfgWdata[1:0]);
      if (cfgWe && cfgAddr == ADDR_W'(ADDR_EN)) begin
        inEnQ  <= cfgWdata[LANES-1:0];
        outEnQ <= cfgWdata[OUTEN_LSB +: LANES];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_poly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fbPoly[g] <= '0;
        ffPoly[g] <= '0;
      end else begin
        if (cfgWe && cfgAddr == ADDR_W'(FB_BASE + g)) fbPoly[g] <= cfgWdata;
        if (cfgWe && cfgAddr == ADDR_W'(FF_BASE + g)) ffPoly[g] <= cfgWdata;
      end
    end
  end

  assign busy  = busyQ;
  assign mode  = modeQ;
  assign inEn  = inEnQ;
  assign outEn = outEnQ;

endmodule

// File: rtl/coder_datapath.sv
module coder_datapath
  import coder_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int LANES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  stepStrobe_t                  strobe,
  input  logic                         inBit,
  input  coderMode_t                   mode,
  input  logic [LANES-1:0]             inEn,
  input  logic [LANES-1:0]             outEn,
  input  logic [LANES-1:0][WIDTH-1:0]  fbPoly,
  input  logic [LANES-1:0][WIDTH-1:0]  ffPoly,
  output logic                         outBit,
  output logic                         outValid
);

  localparam int MSB = WIDTH - 1;

  logic [LANES-1:0][WIDTH-1:0] laneState;
  logic [LANES-1:0][WIDTH-1:0] nextState;
  logic [LANES-1:0] laneFb, laneCarry, laneParity, activeMask, laneTap;
  logic pairMode, joinedFb, codedBit;

  assign pairMode = (mode == MODE_PAIR);
  assign joinedFb = laneState[1][MSB] ^ (inBit & inEn[0]);

  always_comb begin
    case (mode)
      MODE_SOLO: activeMask = LANES'(1);
      MODE_PAIR: activeMask = LANES'(3);
      default:   activeMask = '1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic ownFb, feedIn;
    assign ownFb = laneState[g][MSB] ^ (inBit & inEn[g]);
    if (g < 2) begin : g_joinable
      assign laneFb[g] = pairMode ? joinedFb : ownFb;
    end else begin : g_alone
      assign laneFb[g] = ownFb;
    end
    if (g == 1) begin : g_chain
      assign laneCarry[g] = pairMode & laneState[0][MSB];
      assign feedIn       = !pairMode;
    end else begin : g_nochain
      assign laneCarry[g] = 1'b0;
      assign feedIn       = 1'b1;
    end
    assign nextState[g] = {laneState[g][MSB-1:0], laneCarry[g]}
                        ^ (laneFb[g] ? fbPoly[g] : '0);
    assign laneParity[g] = (^(laneState[g] & ffPoly[g]))
                         ^ (inBit & ffPoly[g][0] & feedIn);
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (pairMode)
        laneTap[i] = (i == 0) ? (outEn[0] & (laneParity[0] ^ laneParity[1])) : 1'b0;
      else
        laneTap[i] = outEn[i] & activeMask[i] & laneParity[i];
    end
    codedBit = ^laneTap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneState <= '0;
      outBit    <= 1'b0;
      outValid  <= 1'b0;
    end else if (strobe.clear) begin
      laneState <= '0;
      outBit    <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.shift;
      if (strobe.shift) begin
        outBit <= codedBit;
        for (int i = 0; i < LANES; i++)
          if (activeMask[i]) laneState[i] <= nextState[i];
      end
    end
  end

endmodule

// File: rtl/multi_lfsr_coder.sv
module multi_lfsr_coder
  import coder_pkg::*;
#(
  parameter int WIDTH     = 24,
  parameter int LANES     = 4,
  parameter int ADDR_W    = 4,
  parameter int OUTEN_LSB = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [WIDTH-1:0]  cfgWdata,
  input  logic              inValid,
  input  logic              inBit,
  input  logic              syncClear,
  output logic              outBit,
  output logic              outValid,
  output logic              busy
);

  stepStrobe_t strobe;
  coderMode_t cfgMode;
  logic [LANES-1:0] inEn, outEn;
  logic [LANES-1:0][WIDTH-1:0] fbPoly, ffPoly;

  coder_ctrl #(.WIDTH(WIDTH), .LANES(LANES), .ADDR_W(ADDR_W), .OUTEN_LSB(OUTEN_LSB)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inValid(inValid), .syncClear(syncClear), .strobe(strobe), .mode(cfgMode),
    .inEn(inEn), .outEn(outEn), .fbPoly(fbPoly), .ffPoly(ffPoly), .busy(busy)
  );

  coder_datapath #(.WIDTH(WIDTH), .LANES(LANES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inBit(inBit), .mode(cfgMode),
    .inEn(inEn), .outEn(outEn), .fbPoly(fbPoly), .ffPoly(ffPoly),
    .outBit(outBit), .outValid(outValid)
  );

endmodule

// File: rtl/coder_checker.sv
module coder_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       syncClear,
  input logic       busy,
  input logic       outValid,
  input logic [1:0] mode
);

  // R4
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !syncClear |=> outValid);

  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R10
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncClear |=> !busy && !outValid);

  // R9
  busy_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !syncClear |=> busy);

  // R9
  busy_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !syncClear |=> busy);

  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(mode));

endmodule

bind multi_lfsr_coder coder_checker chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .syncClear(syncClear),
  .busy(busy), .outValid(outValid), .mode(cfgMode)
);

// File: tb/multi_lfsr_coder_tb_top.sv
module multi_lfsr_coder_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [23:0] cfgWdata = '0;
  logic inValid = 1'b0, inBit = 1'b0, syncClear = 1'b0;
  logic outBit, outValid, busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [23:0] mState [4];
  logic [23:0] mFb [4];
  logic [23:0] mFf [4];
  logic [1:0]  mMode = 2'b00;
  logic [3:0]  mInEn = '0, mOutEn = '0;

  always #10 clk = ~clk;  // 50 MHz

  multi_lfsr_coder dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inValid(inValid), .inBit(inBit), .syncClear(syncClear),
    .outBit(outBit), .outValid(outValid), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [23:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    tick();
    cfgWe = 1'b0;
  endtask

  function automatic logic laneOut(input logic [23:0] s, input logic [23:0] ff, input logic b);
    return (^(s & ff)) ^ (b & ff[0]);
  endfunction

  function automatic logic [23:0] laneStep(input logic [23:0] s, input logic [23:0] fb,
                                           input logic b, input logic en);
    logic f;
    f = s[23] ^ (b & en);
    return (s << 1) ^ (f ? fb : 24'h0);
  endfunction

  // Reference: compute the coded bit from the pre-step state, then step the model.
  task automatic modelStep(input logic b, output logic exp);
    logic [47:0] j, pj, fj;
    logic f;
    exp = 1'b0;
    if (mMode == 2'b11) begin  // R7 chained 48-bit
      j  = {mState[1], mState[0]};
      pj = {mFb[1], mFb[0]};
      fj = {mFf[1], mFf[0]};
      exp = mOutEn[0] & ((^(j & fj)) ^ (b & fj[0]));
      f = j[47] ^ (b & mInEn[0]);
      j = (j << 1) ^ (f ? pj : 48'h0);
      {mState[1], mState[0]} = j;
    end else if (mMode == 2'b10) begin  // R6 lane A only
      exp = mOutEn[0] & laneOut(mState[0], mFf[0], b);
      mState[0] = laneStep(mState[0], mFb[0], b, mInEn[0]);
    end else begin  // R2 four lanes
      for (int i = 0; i < 4; i++) begin
        exp ^= mOutEn[i] & laneOut(mState[i], mFf[i], b);
        mState[i] = laneStep(mState[i], mFb[i], b, mInEn[i]);
      end
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    return (m == 2'b11) ? "R7" : (m == 2'b10) ? "R6" : "R2";
  endfunction

  task automatic shiftBit(input logic b);
    logic exp;
    inValid = 1'b1; inBit = b;
    modelStep(b, exp);
    tick();
    inValid = 1'b0;
    chk("R4 outValid", 32'(outValid), 32'd1);
    chk(modeTag(mMode), 32'(outBit), 32'(exp));
  endtask

  task automatic gap();
    inValid = 1'b0; inBit = 1'b1;
    tick();
    chk("R11 outValid idle", 32'(outValid), 32'd0);
  endtask

  task automatic doClear(input logic withValid);
    syncClear = 1'b1; inValid = withValid; inBit = 1'b1;
    tick();
    syncClear = 1'b0; inValid = 1'b0;
    for (int i = 0; i < 4; i++) mState[i] = '0;
    chk("R10 busy after clear", 32'(busy), 32'd0);
    chk("R10 outValid after clear", 32'(outValid), 32'd0);
  endtask

  task automatic setup(input logic [1:0] m, input logic [3:0] ie, input logic [3:0] oe);
    // R12 map: 0 mode, 1 enables, 2..5 feedback, 6..9 feedforward
    cfgWrite(4'd0, {22'h0, m});
    cfgWrite(4'd1, {oe, 16'h0, ie});
    for (int i = 0; i < 4; i++) begin
      cfgWrite(4'(2 + i), mFb[i]);
      cfgWrite(4'(6 + i), mFf[i]);
    end
    mMode = m; mInEn = ie; mOutEn = oe;
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    logic [3:0] ie;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4; i++) begin
      mState[i] = '0; mFb[i] = '0; mFf[i] = '0;
    end
    repeat (3) tick();
    // R1 reset state
    chk("R1 outValid in reset", 32'(outValid), 32'd0);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    rstN = 1'b1;
    tick();
    chk("R1 outBit after reset", 32'(outBit), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);

    // R5 directed: input enable off, zero feedback, ff bit 0 only: coded bit equals data bit
    mFf[0] = 24'h000001;
    setup(2'b10, 4'b0000, 4'b0001);
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);  // R5 feedforward still sees input
    // R8: output enable off silences lane A
    doClear(1'b0);
    setup(2'b10, 4'b0001, 4'b0000);
    shiftBit(1'b1); shiftBit(1'b1);  // R8

    // R9: mode write while busy is dropped; the stream must keep matching four-lane mode
    doClear(1'b0);
    for (int i = 0; i < 4; i++) begin
      mFb[i] = 24'($urandom); mFf[i] = 24'($urandom);
    end
    setup(2'b00, 4'b1111, 4'b1110);
    for (int k = 0; k < 30; k++) shiftBit(1'($urandom));
    chk("R9 busy held", 32'(busy), 32'd1);
    cfgWrite(4'd0, 24'h000002);  // ignored
    chk("R9 busy still high", 32'(busy), 32'd1);
    for (int k = 0; k < 30; k++) shiftBit(1'($urandom));  // model stays in mode 00

    // R10: clear together with a valid bit wins, lanes restart from zero
    doClear(1'b1);
    for (int k = 0; k < 30; k++) shiftBit(1'($urandom));

    // random configurations across all modes
    for (int c = 0; c < 16; c++) begin
      logic [1:0] m;
      doClear(1'b0);
      m = 2'(c);
      for (int i = 0; i < 4; i++) begin
        mFb[i] = 24'($urandom); mFf[i] = 24'($urandom);
      end
      ie = 4'($urandom);
      if (m == 2'b11) ie[1] = ie[0];  // chained mode wants equal enables
      setup(m, ie, 4'($urandom));
      for (int k = 0; k < 200; k++) begin
        if (($urandom % 8) == 0) gap();
        else shiftBit(1'($urandom));  // R3 next-state rule exercised through outputs
      end
    end
    finishUp();
  end

endmodule